// File: doc/BRIEF.md
# Writeback-Slot Aware Issue Picker

This block is the wakeup-and-select stage for a single execution port. It keeps a small pool of waiting micro-operations. Each one carries two source tags with ready flags, a destination tag and a latency class. In every cycle it sends at most one of them to the port. A candidate goes only when both of its sources are ready and when the cycle in which its result would appear on the port's single result bus is still unclaimed. Among the candidates that pass both tests, it picks the one that has waited longest.

A shift register of claimed result slots makes the collision test one bit lookup per entry. The tag of every finished result is driven out exactly as many cycles after dispatch as its latency class says. The same tag is fed back to the pool, so that waiting operands become ready. New work enters through a valid/ready handshake. The allowed latency classes are a parameter mask, so a build can use the sparse default set or enable other classes, such as four cycles.

Top module: `wb_issue_picker`

## Requirements
- R1: At most one entry is dispatched per cycle, and only an entry whose two source-ready flags are both set. An entry that waits on a tag that is never broadcast is never dispatched.
- R2: No two dispatched operations ever produce a result in the same cycle. A candidate of latency L is held while the result slot L cycles ahead is already claimed. For example, a 1-cycle operation that becomes ready two cycles after a 3-cycle dispatch waits one cycle.
- R3: Among the eligible entries, the one inserted earliest is dispatched. A younger entry goes ahead only while every older one is ineligible.
- R4: An operation dispatched in cycle t with latency L raises `wb_valid` in cycle t+L, with `wb_tag` equal to its destination tag. `wb_valid` is low in every cycle where no result is due.
- R5: A broadcast tag sets the matching source flags of the waiting entries, and such an entry can be dispatched from the next cycle. An operand of an insert that is offered in the same cycle as a matching broadcast is captured as ready.
- R6: The legal latency values are given by the parameter `LAT_MASK`, where bit L set means latency L is allowed. The default allows 1, 3, 5 and 7. An insert with any other latency is refused (`ins_ready` low) and nothing is stored.
- R7: An insert is taken when `ins_valid` and `ins_ready` are both high, and it is visible for dispatch in the next cycle. `ins_ready` is low while all `N_ENT` entries are occupied. An entry is freed in its dispatch cycle.
- R8: Asserting `rst_n` low asynchronously empties the pool, clears all claimed slots, blocks inserts and drops `wb_valid`. Leaving reset takes effect two clock edges after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | New operation offered |
| ins_ready | output | 1 | Offer accepted this cycle |
| ins_src0_tag | input | TAG_W | First source tag |
| ins_src0_rdy | input | 1 | First source already available |
| ins_src1_tag | input | TAG_W | Second source tag |
| ins_src1_rdy | input | 1 | Second source already available |
| ins_dst_tag | input | TAG_W | Destination tag |
| ins_lat | input | LAT_W | Latency class in cycles |
| iss_valid | output | 1 | An operation is dispatched this cycle |
| iss_dst_tag | output | TAG_W | Destination tag of the dispatched operation |
| iss_lat | output | LAT_W | Latency of the dispatched operation |
| wb_valid | output | 1 | A result completes this cycle |
| wb_tag | output | TAG_W | Tag of the completing result |

## Verification
Some properties are checked on every cycle: the grant is single and only goes to an entry with both operands ready, the chosen latency is legal and its slot is free, every result matches a slot claimed one cycle earlier, a full pool refuses inserts, and a granted entry is gone on the next cycle. Only the bench scenarios can show that the choice is the oldest one, that result tags arrive at the exact cycle, that a broadcast wakes an entry on the following cycle, and that the pool is empty after reset. They do this by replaying one schedule of mixed latencies and comparing every dispatch and every result cycle with hand-computed timing.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
  localparam int DEF_N_ENT   = 4;
  localparam int DEF_TAG_W   = 4;
  localparam int DEF_MAX_LAT = 7;
  // bit L set: latency L legal (1, 3, 5, 7)
  localparam logic [DEF_MAX_LAT:0] DEF_LAT_MASK = 8'b1010_1010;
endpackage

// File: rtl/wbp_entries.sv
module wbp_entries #(
  parameter int N     = 4,
  parameter int TAG_W = 4,
  parameter int LAT_W = 3,
  parameter int AGE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_fire,
  input  logic [TAG_W-1:0] ins_s0_tag,
  input  logic             ins_s0_rdy,
  input  logic [TAG_W-1:0] ins_s1_tag,
  input  logic             ins_s1_rdy,
  input  logic [TAG_W-1:0] ins_dst,
  input  logic [LAT_W-1:0] ins_lat,
  input  logic             wake_vld,
  input  logic [TAG_W-1:0] wake_tag,
  input  logic [N-1:0]     grant,
  output logic [N-1:0]     ent_vld,
  output logic [N-1:0]     ent_rdy,
  output logic [LAT_W-1:0] ent_lat [N],
  output logic [TAG_W-1:0] ent_dst [N],
  output logic [AGE_W-1:0] ent_age [N],
  output logic             has_free
);
  logic [N-1:0]     vld_q, vld_d, r0_q, r0_d, r1_q, r1_d, slot_sel;
  logic [TAG_W-1:0] s0_q [N];
  logic [TAG_W-1:0] s1_q [N];
  logic [AGE_W-1:0] age_q [N];
  logic [AGE_W-1:0] age_d [N];
  logic [AGE_W-1:0] gage;
  logic             found;

  always_comb begin
    slot_sel = '0;
    found    = 1'b0;
    gage     = '0;
    for (int i = 0; i < N; i++) begin
      if (!vld_q[i] && !found) begin
        slot_sel[i] = 1'b1;
        found       = 1'b1;
      end
      if (grant[i]) gage = age_q[i];
    end
    for (int i = 0; i < N; i++) begin
      vld_d[i] = (vld_q[i] & ~grant[i]) | (ins_fire & slot_sel[i]);
      r0_d[i]  = r0_q[i] | (wake_vld && s0_q[i] == wake_tag);
      r1_d[i]  = r1_q[i] | (wake_vld && s1_q[i] == wake_tag);
      age_d[i] = age_q[i] + AGE_W'(ins_fire) - AGE_W'((|grant) && age_q[i] > gage);
      if (ins_fire && slot_sel[i]) begin
        r0_d[i]  = ins_s0_rdy | (wake_vld && ins_s0_tag == wake_tag);
        r1_d[i]  = ins_s1_rdy | (wake_vld && ins_s1_tag == wake_tag);
        age_d[i] = '0;
      end
    end
  end

  // control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      r0_q  <= '0;
      r1_q  <= '0;
      for (int i = 0; i < N; i++) age_q[i] <= '0;
    end else begin
      vld_q <= vld_d;
      r0_q  <= r0_d;
      r1_q  <= r1_d;
      for (int i = 0; i < N; i++) age_q[i] <= age_d[i];
    end
  end

  // payload, loaded only on insert
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (ins_fire && slot_sel[i]) begin
        s0_q[i]    <= ins_s0_tag;
        s1_q[i]    <= ins_s1_tag;
        ent_dst[i] <= ins_dst;
        ent_lat[i] <= ins_lat;
      end
    end
  end

  assign ent_vld  = vld_q;
  assign ent_rdy  = r0_q & r1_q;
  assign ent_age  = age_q;
  assign has_free = ~&vld_q;
endmodule

// File: rtl/wbp_pick.sv
module wbp_pick #(
  parameter int N       = 4,
  parameter int LAT_W   = 3,
  parameter int AGE_W   = 2,
  parameter int MAX_LAT = 7
) (
  input  logic [N-1:0]     ent_vld,
  input  logic [N-1:0]     ent_rdy,
  input  logic [LAT_W-1:0] ent_lat [N],
  input  logic [AGE_W-1:0] ent_age [N],
  input  logic [MAX_LAT:0] resv,
  output logic [N-1:0]     grant
);
  logic [N-1:0]     elig;
  logic [AGE_W-1:0] best;
  logic             found;

  for (genvar g = 0; g < N; g++) begin : g_elig
    assign elig[g] = ent_vld[g] & ent_rdy[g] & ~resv[ent_lat[g]];
  end

  always_comb begin
    grant = '0;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || ent_age[i] > best)) begin
        grant    = '0;
        grant[i] = 1'b1;
        best     = ent_age[i];
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/wbp_resv.sv
module wbp_resv #(
  parameter int MAX_LAT = 7,
  parameter int LAT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp,
  input  logic [LAT_W-1:0] disp_lat,
  output logic [MAX_LAT:0] resv
);
  logic [MAX_LAT:1] q, d;

  always_comb begin
    d = '0;
    for (int k = 1; k < MAX_LAT; k++)
      d[k] = q[k+1] | (disp && disp_lat == LAT_W'(k + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign resv = {q, 1'b0};
endmodule

// File: rtl/wbp_tag_pipe.sv
module wbp_tag_pipe #(
  parameter int MAX_LAT = 7,
  parameter int LAT_W   = 3,
  parameter int TAG_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp,
  input  logic [LAT_W-1:0] disp_lat,
  input  logic [TAG_W-1:0] disp_tag,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag
);
  logic [MAX_LAT-1:0] v_q, v_d;
  logic [TAG_W-1:0]   t_q [MAX_LAT];
  logic [TAG_W-1:0]   t_d [MAX_LAT];

  always_comb begin
    for (int k = 0; k < MAX_LAT - 1; k++) begin
      v_d[k] = v_q[k+1];
      t_d[k] = t_q[k+1];
    end
    v_d[MAX_LAT-1] = 1'b0;
    t_d[MAX_LAT-1] = '0;
    for (int k = 0; k < MAX_LAT; k++) begin
      if (disp && disp_lat == LAT_W'(k + 1)) begin
        v_d[k] = 1'b1;
        t_d[k] = disp_tag;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < MAX_LAT; k++) t_q[k] <= t_d[k];
  end

  assign wb_valid = v_q[0];
  assign wb_tag   = t_q[0];
endmodule

// File: rtl/wb_issue_picker.sv
module wb_issue_picker
  import wbp_pkg::*;
#(
  parameter int N_ENT   = DEF_N_ENT,
  parameter int TAG_W   = DEF_TAG_W,
  parameter int MAX_LAT = DEF_MAX_LAT,
  parameter logic [MAX_LAT:0] LAT_MASK = DEF_LAT_MASK,
  localparam int LAT_W  = $clog2(MAX_LAT + 1),
  localparam int AGE_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [TAG_W-1:0] ins_src0_tag,
  input  logic             ins_src0_rdy,
  input  logic [TAG_W-1:0] ins_src1_tag,
  input  logic             ins_src1_rdy,
  input  logic [TAG_W-1:0] ins_dst_tag,
  input  logic [LAT_W-1:0] ins_lat,
  output logic             iss_valid,
  output logic [TAG_W-1:0] iss_dst_tag,
  output logic [LAT_W-1:0] iss_lat,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag
);
  logic             rst_meta, rst_q;
  logic             has_free, lat_ok, ins_fire;
  logic [N_ENT-1:0] grant, ent_vld, ent_rdy;
  logic [LAT_W-1:0] ent_lat [N_ENT];
  logic [TAG_W-1:0] ent_dst [N_ENT];
  logic [AGE_W-1:0] ent_age [N_ENT];
  logic [MAX_LAT:0] resv;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q, rst_meta} <= 2'b00;
    else        {rst_q, rst_meta} <= {rst_meta, 1'b1};
  end

  assign lat_ok    = (32'(ins_lat) <= MAX_LAT) && LAT_MASK[ins_lat];
  assign ins_ready = rst_q & has_free & lat_ok;
  assign ins_fire  = ins_valid & ins_ready;

  wbp_entries #(.N(N_ENT), .TAG_W(TAG_W), .LAT_W(LAT_W), .AGE_W(AGE_W)) u_ent (
    .clk(clk), .rst_n(rst_q), .ins_fire(ins_fire),
    .ins_s0_tag(ins_src0_tag), .ins_s0_rdy(ins_src0_rdy),
    .ins_s1_tag(ins_src1_tag), .ins_s1_rdy(ins_src1_rdy),
    .ins_dst(ins_dst_tag), .ins_lat(ins_lat),
    .wake_vld(wb_valid), .wake_tag(wb_tag), .grant(grant),
    .ent_vld(ent_vld), .ent_rdy(ent_rdy), .ent_lat(ent_lat),
    .ent_dst(ent_dst), .ent_age(ent_age), .has_free(has_free)
  );

  wbp_pick #(.N(N_ENT), .LAT_W(LAT_W), .AGE_W(AGE_W), .MAX_LAT(MAX_LAT)) u_pick (
    .ent_vld(ent_vld), .ent_rdy(ent_rdy), .ent_lat(ent_lat),
    .ent_age(ent_age), .resv(resv), .grant(grant)
  );

  always_comb begin
    iss_dst_tag = '0;
    iss_lat     = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (grant[i]) begin
        iss_dst_tag = ent_dst[i];
        iss_lat     = ent_lat[i];
      end
    end
  end
  assign iss_valid = |grant;

  wbp_resv #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_resv (
    .clk(clk), .rst_n(rst_q), .disp(iss_valid), .disp_lat(iss_lat), .resv(resv)
  );

  wbp_tag_pipe #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W), .TAG_W(TAG_W)) u_pipe (
    .clk(clk), .rst_n(rst_q), .disp(iss_valid), .disp_lat(iss_lat),
    .disp_tag(iss_dst_tag), .wb_valid(wb_valid), .wb_tag(wb_tag)
  );
endmodule

// File: rtl/wbp_chk.sv
module wbp_chk #(
  parameter int N_ENT   = 4,
  parameter int MAX_LAT = 7,
  parameter int LAT_W   = 3,
  parameter logic [MAX_LAT:0] LAT_MASK = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_ENT-1:0] grant,
  input logic [N_ENT-1:0] ent_vld,
  input logic [N_ENT-1:0] ent_rdy,
  input logic [MAX_LAT:0] resv,
  input logic             iss_valid,
  input logic [LAT_W-1:0] iss_lat,
  input logic             wb_valid,
  input logic             ins_ready
);
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (iss_valid == (|grant)));

  a_r1_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~(ent_vld & ent_rdy)) == '0);

  a_r2_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !resv[iss_lat]);

  a_r4_wb_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid == $past(resv[1] | (iss_valid && iss_lat == LAT_W'(1))));

  a_r6_lat_legal: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> LAT_MASK[iss_lat]);

  a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (&ent_vld) |-> !ins_ready);

  a_r7_free_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |=> ((ent_vld & $past(grant)) == '0));
endmodule

bind wb_issue_picker wbp_chk #(
  .N_ENT(N_ENT), .MAX_LAT(MAX_LAT), .LAT_W(LAT_W), .LAT_MASK(LAT_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_q), .grant(grant), .ent_vld(ent_vld),
  .ent_rdy(ent_rdy), .resv(resv), .iss_valid(iss_valid),
  .iss_lat(iss_lat), .wb_valid(wb_valid), .ins_ready(ins_ready)
);

// File: tb/wb_issue_picker_tb_top.sv
module wb_issue_picker_tb_top;
  logic       clk, rst_n;
  logic       ins_valid, ins_ready;
  logic [3:0] ins_src0_tag, ins_src1_tag, ins_dst_tag;
  logic       ins_src0_rdy, ins_src1_rdy;
  logic [2:0] ins_lat;
  logic       iss_valid, wb_valid;
  logic [3:0] iss_dst_tag, wb_tag;
  logic [2:0] iss_lat;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  wb_issue_picker dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_src0_tag(ins_src0_tag), .ins_src0_rdy(ins_src0_rdy),
    .ins_src1_tag(ins_src1_tag), .ins_src1_rdy(ins_src1_rdy),
    .ins_dst_tag(ins_dst_tag), .ins_lat(ins_lat),
    .iss_valid(iss_valid), .iss_dst_tag(iss_dst_tag), .iss_lat(iss_lat),
    .wb_valid(wb_valid), .wb_tag(wb_tag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // insert cycle, latency, dst, src0 tag/rdy, src1 tag/rdy, expected dispatch cycle
  typedef struct packed {
    int cyc; int lat; int dst; int s0; int s0r; int s1; int s1r; int iss;
  } vec_t;
  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{0, 3, 1, 0, 1, 0, 1, 1},
    '{2, 1, 2, 0, 1, 0, 1, 4},
    '{3, 5, 3, 0, 1, 0, 1, 5},
    '{4, 1, 4, 3, 0, 0, 1, 11},
    '{10, 3, 5, 0, 1, 3, 0, 12},
    '{12, 7, 6, 0, 1, 0, 1, 13},
    '{13, 7, 7, 0, 1, 0, 1, 14},
    '{14, 5, 8, 0, 1, 0, 1, 17},
    '{15, 1, 9, 0, 1, 0, 1, 16}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_ins();
    ins_valid = 1'b0; ins_lat = 3'd1; ins_dst_tag = '0;
    ins_src0_tag = '0; ins_src0_rdy = 1'b1;
    ins_src1_tag = '0; ins_src1_rdy = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      summary();
      $finish;
    end
  end

  initial begin
    logic       e_iss, e_wb;
    logic [3:0] e_dst, e_wt;
    logic [2:0] e_lat;
    idle_ins();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 ready after reset", ins_ready, 1);
    chk("R8 no dispatch after reset", iss_valid, 0);
    chk("R8 no result after reset", wb_valid, 0);
    @(negedge clk);

    // scheduled mix of latency classes
    for (int k = 0; k < 25; k++) begin
      idle_ins();
      for (int v = 0; v < NV; v++) begin
        if (TBL[v].cyc == k) begin
          ins_valid    = 1'b1;
          ins_lat      = 3'(TBL[v].lat);
          ins_dst_tag  = 4'(TBL[v].dst);
          ins_src0_tag = 4'(TBL[v].s0);
          ins_src0_rdy = TBL[v].s0r[0];
          ins_src1_tag = 4'(TBL[v].s1);
          ins_src1_rdy = TBL[v].s1r[0];
        end
      end
      #1;
      if (ins_valid) chk("R7 insert accepted", ins_ready, 1);
      e_iss = 0; e_dst = 0; e_lat = 0; e_wb = 0; e_wt = 0;
      for (int v = 0; v < NV; v++) begin
        if (TBL[v].iss == k) begin
          e_iss = 1; e_dst = 4'(TBL[v].dst); e_lat = 3'(TBL[v].lat);
        end
        if (TBL[v].iss + TBL[v].lat == k) begin
          e_wb = 1; e_wt = 4'(TBL[v].dst);
        end
      end
      chk("R3 dispatch valid", iss_valid, e_iss);
      if (e_iss) begin
        chk("R3 dispatch tag", iss_dst_tag, e_dst);
        chk("R3 dispatch latency", iss_lat, e_lat);
      end
      chk("R4 result valid", wb_valid, e_wb);
      if (e_wb) chk("R4 result tag", wb_tag, e_wt);
      if (k == 3)  chk("R2 1c held behind 3c result", iss_valid, 0);
      if (k == 4)  chk("R3 oldest of two eligible", iss_dst_tag, 2);
      if (k == 11) chk("R5 woken entry dispatched", iss_dst_tag, 4);
      if (k == 12) chk("R5 insert-time capture", iss_dst_tag, 5);
      if (k == 16) chk("R3 younger passes slot-blocked older", iss_dst_tag, 9);
      if (k == 17) chk("R2 blocked entry goes on free slot", iss_dst_tag, 8);
      @(negedge clk);
    end

    // illegal latency classes
    ins_valid = 1'b1; ins_lat = 3'd2; ins_dst_tag = 4'd12;
    #1; chk("R6 latency 2 refused", ins_ready, 0);
    @(negedge clk);
    ins_lat = 3'd4;
    #1; chk("R6 latency 4 refused", ins_ready, 0);
    @(negedge clk);
    idle_ins();
    #1; chk("R6 nothing stored", iss_valid, 0);
    @(negedge clk);
    #1; chk("R6 nothing stored later", iss_valid, 0);
    @(negedge clk);

    // fill the pool with entries waiting on a tag never broadcast
    for (int i = 0; i < 4; i++) begin
      ins_valid = 1'b1; ins_lat = 3'd1; ins_dst_tag = 4'(10 + i);
      ins_src0_tag = 4'd14; ins_src0_rdy = 1'b0;
      #1; chk("R7 insert into free slot", ins_ready, 1);
      @(negedge clk);
    end
    idle_ins();
    #1;
    chk("R7 full pool stalls", ins_ready, 0);
    chk("R1 unready entries held", iss_valid, 0);
    @(negedge clk);
    #1; chk("R1 unready entries still held", iss_valid, 0);

    // reset empties the pool
    rst_n = 1'b0;
    #1;
    chk("R8 inserts blocked in reset", ins_ready, 0);
    chk("R8 no dispatch in reset", iss_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 pool empty after reset", ins_ready, 1);
    chk("R8 no dispatch after second reset", iss_valid, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule